// File: doc/BRIEF.md
# Outstanding Miss Tracker with Stall Policy

This block sits beside a processor's cache and keeps one entry for every cache line whose miss is still in flight. Each entry holds the line address, whether a load is waiting on it, and which of the line's double-word beats have come back. The processor presents a miss with its line address and kind. The tracker either takes the miss into a new entry, which launches a request outward and says whether ownership is needed, or folds it into the entry already open for that line. Beats of fill data return one per cycle, each tagged with the line address and its beat index within the line.

The stall output means that the request presented in this cycle is not taken and must be held. Loads are blocking, but only up to the first returned double-word of their line. Stores and both prefetch kinds run ahead of the processor until every entry is in use. An entry retires once all sixteen 8-byte beats of its 128-byte line have arrived. A fill beat that names no open line is dropped and leaves a sticky error flag.

Top module: `miss_tracker`

## Requirements
- R1: When a load is taken into a new entry, or is merged into an entry that has not yet received any beat, stall is high from the next cycle up to and including the cycle in which that entry's first beat arrives. Stall is low in the cycle after that. No request is taken while stall is held for a load.
- R2: A miss of kind store (`req_kind` 2'b01), prefetch (2'b10) or prefetch with ownership (2'b11) is taken with stall low whenever a free entry exists or its line already has an entry.
- R3: At most NUM_ENTRIES (4) lines are tracked. A miss to a new line while all entries are valid gets stall high, causes no issue and leaves occupancy unchanged. It is taken in the first cycle in which an entry is free.
- R4: A miss to a line that already has an entry merges into that entry. It allocates nothing and issues nothing. A load (2'b00) merging into an entry that has already received a beat causes no stall.
- R5: Taking a miss into a new entry pulses `issue_valid` for one cycle with `issue_line` equal to the request line. `issue_own` is 1 for store and prefetch-with-ownership, and 0 for load and plain prefetch.
- R6: A line's fill is 16 beats with 4-bit indices 0..15 in any order. A repeated index counts once.
- R7: An entry is freed in the cycle after its 16th distinct beat. During that beat's cycle, occupancy still counts it.
- R8: `load_wake` is high for one cycle, in the cycle of the first beat of an entry that holds a load. It stays low for later beats and for entries without a load.
- R9: A fill beat whose line matches no valid entry changes no entry and sets `fill_err` from the next cycle. `fill_err` then stays high until reset.
- R10: A miss to a line whose entry receives its final beat in the same cycle is not merged. It takes a fresh entry and issues.
- R11: After reset, stall, load_wake, issue_valid and fill_err are low and occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A miss is presented |
| req_line | input | LINE_W | Line address of the miss |
| req_kind | input | 2 | 00 load, 01 store, 10 prefetch, 11 prefetch with ownership |
| fill_valid | input | 1 | A fill beat is present |
| fill_line | input | LINE_W | Line address of the fill beat |
| fill_beat | input | 4 | Double-word index of the beat within the line |
| stall | output | 1 | Presented miss is not taken; processor must hold |
| load_wake | output | 1 | First beat arrived for an entry holding a load |
| occupancy | output | $clog2(NUM_ENTRIES+1) | Number of valid entries |
| fill_err | output | 1 | Sticky: a beat arrived for no open line |
| issue_valid | output | 1 | A new line request is launched |
| issue_line | output | LINE_W | Line address of the launched request |
| issue_own | output | 1 | Launched request asks for ownership |

## Verification
The bench targets the boundary between a full tracker and the release of an entry. A design that freed an entry one cycle early, or merged into a retiring entry, would drop a miss or hold the stall for too long. It repeats a beat index inside one fill, which a counter-based design would wrongly retire early. It also delivers a first beat to an entry holding no load, where a loose wake would falsely release the processor. It checks that a load merging behind an already-started fill does not stall, and that a stray beat sets a flag without touching any entry.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int LINE_BYTES = 128;
    localparam int BEAT_BYTES = 8;
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_W     = $clog2(BEATS);

    typedef enum logic [1:0] {
        KIND_LOAD     = 2'b00,
        KIND_STORE    = 2'b01,
        KIND_PREF     = 2'b10,
        KIND_PREF_OWN = 2'b11
    } miss_kind_e;

    typedef struct packed {
        logic             valid;
        logic             has_load;
        logic [BEATS-1:0] got;
    } ent_stat_t;

    function automatic logic wants_ownership(miss_kind_e k);
        return (k == KIND_STORE) || (k == KIND_PREF_OWN);
    endfunction

    function automatic logic is_blocking(miss_kind_e k);
        return k == KIND_LOAD;
    endfunction

endpackage

// File: rtl/mt_entry.sv
module mt_entry
    import mt_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              alloc_load,
    input  logic              merge_load,
    input  logic [LINE_W-1:0] req_line,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [BEAT_W-1:0] fill_beat,
    output logic              valid,
    output logic              req_hit,
    output logic              fill_hit,
    output logic              first_now,
    output logic              done_now,
    output logic              got_first,
    output logic              has_load
);

    ent_stat_t         st_q;
    logic [LINE_W-1:0] line_q;
    logic [BEATS-1:0]  got_next;

    always_comb begin
        fill_hit = fill_valid && st_q.valid && (line_q == fill_line);
        got_next = st_q.got;
        if (fill_hit) got_next[fill_beat] = 1'b1;
        first_now = fill_hit && (st_q.got == '0);
        done_now  = fill_hit && (&got_next);
        req_hit   = st_q.valid && (line_q == req_line) && !done_now;
        valid     = st_q.valid;
        got_first = |st_q.got;
        has_load  = st_q.has_load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            line_q <= '0;
        end else if (alloc_en) begin
            st_q.valid    <= 1'b1;
            st_q.has_load <= alloc_load;
            st_q.got      <= '0;
            line_q        <= alloc_line;
        end else if (done_now) begin
            st_q <= '0;
        end else begin
            st_q.got <= got_next;
            if (merge_load) st_q.has_load <= 1'b1;
        end
    end

    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !st_q.valid); // R3
    AST_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done_now |=> !valid); // R7
    AST_MERGE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        merge_load |-> st_q.valid); // R4

endmodule

// File: rtl/mt_select.sv
module mt_select #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     hit_vec,
    input  logic [N-1:0]     valid_vec,
    output logic             hit_any,
    output logic [IDX_W-1:0] hit_idx,
    output logic             free_any,
    output logic [IDX_W-1:0] free_idx
);

    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R4
    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        (hit_vec & ~valid_vec) == '0); // R4

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
    import mt_pkg::*;
#(
    parameter int LINE_W      = 26,
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int OCC_W      = $clog2(NUM_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_line,
    input  logic [1:0]        req_kind,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [BEAT_W-1:0] fill_beat,
    output logic              stall,
    output logic              load_wake,
    output logic [OCC_W-1:0]  occupancy,
    output logic              fill_err,
    output logic              issue_valid,
    output logic [LINE_W-1:0] issue_line,
    output logic              issue_own
);

    miss_kind_e kind;
    logic       is_load;

    logic [NUM_ENTRIES-1:0] valid_vec, hit_vec, fill_hit_vec, first_vec;
    logic [NUM_ENTRIES-1:0] done_vec, got_first_vec, has_load_vec;
    logic [NUM_ENTRIES-1:0] alloc_vec, merge_load_vec;

    logic             hit_any, free_any;
    logic [IDX_W-1:0] hit_idx, free_idx;

    logic             can_take, do_merge, do_alloc, load_waits;
    logic             wait_q;
    logic [IDX_W-1:0] wait_idx_q;
    logic             err_q;

    assign kind    = miss_kind_e'(req_kind);
    assign is_load = is_blocking(kind);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        mt_entry #(.LINE_W(LINE_W)) u_ent (
            .clk        (clk),
            .rst        (rst),
            .alloc_en   (alloc_vec[g]),
            .alloc_line (req_line),
            .alloc_load (is_load),
            .merge_load (merge_load_vec[g]),
            .req_line   (req_line),
            .fill_valid (fill_valid),
            .fill_line  (fill_line),
            .fill_beat  (fill_beat),
            .valid      (valid_vec[g]),
            .req_hit    (hit_vec[g]),
            .fill_hit   (fill_hit_vec[g]),
            .first_now  (first_vec[g]),
            .done_now   (done_vec[g]),
            .got_first  (got_first_vec[g]),
            .has_load   (has_load_vec[g])
        );
    end

    mt_select #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx),
        .free_any  (free_any),
        .free_idx  (free_idx)
    );

    always_comb begin
        can_take = req_valid && !wait_q;
        do_merge = can_take && hit_any;
        do_alloc = can_take && !hit_any && free_any;
        load_waits = is_load && (do_alloc ||
                     (do_merge && !got_first_vec[hit_idx] && !first_vec[hit_idx]));
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            alloc_vec[i]      = do_alloc && (free_idx == IDX_W'(i));
            merge_load_vec[i] = do_merge && is_load && (hit_idx == IDX_W'(i));
        end
        occupancy = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            occupancy = occupancy + OCC_W'(valid_vec[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q     <= 1'b0;
            wait_idx_q <= '0;
            err_q      <= 1'b0;
        end else begin
            if (wait_q && first_vec[wait_idx_q]) begin
                wait_q <= 1'b0;
            end else if (load_waits) begin
                wait_q     <= 1'b1;
                wait_idx_q <= do_alloc ? free_idx : hit_idx;
            end
            if (fill_valid && (fill_hit_vec == '0)) err_q <= 1'b1;
        end
    end

    assign stall       = wait_q || (req_valid && !hit_any && !free_any);
    assign load_wake   = |(first_vec & has_load_vec);
    assign fill_err    = err_q;
    assign issue_valid = do_alloc;
    assign issue_line  = req_line;
    assign issue_own   = do_alloc && wants_ownership(kind);

    AST_LOAD_ISSUE_STALLS: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && is_load) |=> stall); // R1
    AST_WAKE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        load_wake |=> !wait_q); // R8
    AST_FULL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (occupancy == OCC_W'(NUM_ENTRIES)) |-> !issue_valid); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        fill_err |=> fill_err); // R9
    AST_OWN_WITH_ISSUE: assert property (@(posedge clk) disable iff (rst)
        issue_own |-> issue_valid); // R5

endmodule

// File: tb/miss_tracker_test.sv
module miss_tracker_test;

    localparam int LW = 26;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [LW-1:0] req_line;
    logic [1:0]    req_kind;
    logic          fill_valid;
    logic [LW-1:0] fill_line;
    logic [3:0]    fill_beat;
    logic          stall, load_wake, fill_err, issue_valid, issue_own;
    logic [2:0]    occupancy;
    logic [LW-1:0] issue_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    miss_tracker #(.LINE_W(LW), .NUM_ENTRIES(4)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_line(req_line), .req_kind(req_kind),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_beat(fill_beat),
        .stall(stall), .load_wake(load_wake), .occupancy(occupancy),
        .fill_err(fill_err), .issue_valid(issue_valid),
        .issue_line(issue_line), .issue_own(issue_own)
    );

    typedef struct packed {
        logic       rv;
        logic [1:0] k;
        logic [7:0] rl;
        logic       fv;
        logic [7:0] fl;
        logic [3:0] fb;
        logic       s;
        logic       w;
        logic [2:0] occ;
        logic       iss;
        logic       own;
        logic       err;
    } vec_t;

    localparam vec_t VT [11] = '{
        '{1'b1, 2'd1, 8'h10, 1'b0, 8'h00, 4'd0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0}, // R2 R5 store
        '{1'b1, 2'd2, 8'h20, 1'b0, 8'h00, 4'd0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0}, // R2 R5 prefetch
        '{1'b1, 2'd3, 8'h30, 1'b0, 8'h00, 4'd0, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 1'b0}, // R2 R5 pref-own
        '{1'b1, 2'd1, 8'h10, 1'b0, 8'h00, 4'd0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0}, // R4 merge
        '{1'b1, 2'd1, 8'h40, 1'b0, 8'h00, 4'd0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0}, // R2 fourth line
        '{1'b1, 2'd2, 8'h50, 1'b0, 8'h00, 4'd0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0}, // R3 full
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h99, 4'd0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0}, // R9 stray beat
        '{1'b1, 2'd0, 8'h20, 1'b0, 8'h00, 4'd0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1}, // R1 R4 load merge
        '{1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1}, // R1 waiting
        '{1'b1, 2'd1, 8'h50, 1'b1, 8'h20, 4'd5, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1}, // R1 R8 first beat
        '{1'b1, 2'd1, 8'h50, 1'b0, 8'h00, 4'd0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1}  // R3 full again
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic rv, input logic [1:0] k, input logic [7:0] rl,
                       input logic fv, input logic [7:0] fl, input logic [3:0] fb);
        @(negedge clk);
        req_valid  = rv;
        req_kind   = k;
        req_line   = LW'(rl);
        fill_valid = fv;
        fill_line  = LW'(fl);
        fill_beat  = fb;
        #2;
    endtask

    task automatic idle();
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0; req_kind = 2'd0; req_line = '0;
        fill_valid = 1'b0; fill_line = '0; fill_beat = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R11 stall", stall, 0);
        chk("R11 occupancy", occupancy, 0);
        chk("R11 fill_err", fill_err, 0);
        chk("R11 load_wake", load_wake, 0);
        chk("R11 issue_valid", issue_valid, 0);

        // Vector table walk
        for (int i = 0; i < 11; i++) begin
            cyc(VT[i].rv, VT[i].k, VT[i].rl, VT[i].fv, VT[i].fl, VT[i].fb);
            chk($sformatf("row %0d stall", i), stall, VT[i].s);
            chk($sformatf("row %0d wake", i), load_wake, VT[i].w);
            chk($sformatf("row %0d occupancy", i), occupancy, VT[i].occ);
            chk($sformatf("row %0d issue", i), issue_valid, VT[i].iss);
            chk($sformatf("row %0d own", i), issue_own, VT[i].own);
            chk($sformatf("row %0d err", i), fill_err, VT[i].err);
            if (VT[i].iss) chk($sformatf("row %0d issue_line R5", i), int'(issue_line), int'(VT[i].rl));
        end

        // R1 R6 R7 R8: load blocks until first beat; duplicate beat; release timing
        do_reset();
        cyc(1'b1, 2'd0, 8'h11, 1'b0, 8'h00, 4'd0);
        chk("R1 load taken", stall, 0);
        chk("R5 load own", issue_own, 0);
        idle();
        chk("R1 stall while waiting", stall, 1);
        cyc(1'b1, 2'd1, 8'h12, 1'b1, 8'h11, 4'd3);
        chk("R8 wake on first beat", load_wake, 1);
        chk("R1 stall in first-beat cycle", stall, 1);
        chk("R1 no issue while waiting", issue_valid, 0);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'h11, 4'd3);
        chk("R8 no wake on later beat", load_wake, 0);
        chk("R1 released", stall, 0);
        for (int b = 0; b < 16; b++) begin
            if (b != 3) begin
                cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'h11, 4'(b));
                chk("R6 R7 entry held through fill", occupancy, 1);
            end
        end
        idle();
        chk("R7 freed after last beat", occupancy, 0);

        // R10: miss to a retiring line allocates afresh
        do_reset();
        cyc(1'b1, 2'd1, 8'h22, 1'b0, 8'h00, 4'd0);
        chk("R5 store own", issue_own, 1);
        for (int b = 0; b < 15; b++) cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'h22, 4'(b));
        cyc(1'b1, 2'd1, 8'h22, 1'b1, 8'h22, 4'd15);
        chk("R10 fresh issue", issue_valid, 1);
        chk("R10 no stall", stall, 0);
        idle();
        chk("R10 new entry held", occupancy, 1);

        // R4 R8: load merging behind a started fill
        do_reset();
        cyc(1'b1, 2'd2, 8'h33, 1'b0, 8'h00, 4'd0);
        chk("R5 prefetch own", issue_own, 0);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'h33, 4'd0);
        chk("R8 no wake without load", load_wake, 0);
        cyc(1'b1, 2'd0, 8'h33, 1'b0, 8'h00, 4'd0);
        chk("R4 merge no issue", issue_valid, 0);
        chk("R4 merge taken", stall, 0);
        idle();
        chk("R4 no stall after merge", stall, 0);
        chk("R4 occupancy", occupancy, 1);

        // R3: release of a full tracker
        do_reset();
        for (int l = 0; l < 4; l++) cyc(1'b1, 2'd1, 8'(8'h40 + l), 1'b0, 8'h00, 4'd0);
        cyc(1'b1, 2'd1, 8'h44, 1'b0, 8'h00, 4'd0);
        chk("R3 full stall", stall, 1);
        chk("R3 full no issue", issue_valid, 0);
        for (int b = 0; b < 16; b++) begin
            cyc(1'b1, 2'd1, 8'h44, 1'b1, 8'h41, 4'(b));
            chk("R3 held while full", stall, 1);
        end
        cyc(1'b1, 2'd1, 8'h44, 1'b0, 8'h00, 4'd0);
        chk("R3 taken once free", stall, 0);
        chk("R3 issue once free", issue_valid, 1);
        idle();
        chk("R3 occupancy back to full", occupancy, 4);

        // R9: stray beat ignored, flag sticky until reset
        do_reset();
        cyc(1'b1, 2'd1, 8'h50, 1'b0, 8'h00, 4'd0);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'h60, 4'd0);
        idle();
        chk("R9 err set", fill_err, 1);
        chk("R9 entry untouched", occupancy, 1);
        repeat (3) idle();
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 8'h50, 4'd0);
        idle();
        chk("R9 err sticky", fill_err, 1);
        do_reset();
        chk("R11 err cleared by reset", fill_err, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule